// File: doc/BRIEF.md
# Presence-Tagged Word Memory

This block is a small word-addressed store in which each data word carries a single presence flag. A producer writes a word, and the write marks it as present. A consumer that reads a present word gets the data back one cycle after its request is taken, as with any registered memory. A consumer that reads an absent word is not turned away. The request is parked in a small table of waiters, and the block answers it in hardware as soon as some producer writes that address. This gives producer/consumer synchronization at the level of single words, which works like a scoreboard placed inside the memory.

There is one write port and one clear port. A clear marks a word absent so that it can be reused in the next round of a computation. Several requesters share the read side. Each requester has its own valid/ready request handshake and its own response lane. Only one read per requester is outstanding at a time. The number of waiting reads is bounded by the table size.

Top module: `fe_tag_mem`

## Requirements
- R1: After reset every word is absent and no response lane is valid, so a first read of any address is parked and produces no response until that address is written.
- R2: A read that is accepted (`rd_valid` and `rd_ready` high) to a present word produces `rsp_valid` on that requester's lane exactly one cycle later, carrying the stored data.
- R3: A write stores `wr_data` at `wr_addr` and marks the word present, so later reads of that address are answered with that data without waiting.
- R4: A read of an absent word is accepted while a waiter slot is free, and it produces no response until a write to that address. Its response then appears in the cycle after the write and carries the written data.
- R5: A single write releases every read waiting on its address, and all of their responses appear in the same cycle.
- R6: When a read and a write target the same absent address in the same cycle, the write is seen first. The read is accepted and answered in the next cycle with the new data.
- R7: A clear makes a word absent, so a following read waits for the next write. If a clear and a write hit the same address in the same cycle, the write wins and the word holds the written data.
- R8: At most PEND_N reads wait at once (default 4). While all slots are taken, a read of an absent word sees `rd_ready` low. A read of a present word is still accepted. One cycle after a release, a slot is free again.
- R9: A requester with a waiting read sees `rd_ready` low until its response appears. In the response cycle it may issue a new read.
- R10: When several requesters ask for waiter slots in the same cycle, the free slots go to the lowest-numbered requesters first. The others see `rd_ready` low.
- R11: A write to one address does not release reads waiting on a different address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| clr_valid | input | 1 | Clear strobe: mark a word absent |
| clr_addr | input | ADDR_W | Word address to clear |
| rd_valid | input | NUM_RD | Per-requester read request valid |
| rd_addr | input | NUM_RD*ADDR_W | Per-requester read address, requester i at bits [i*ADDR_W +: ADDR_W] |
| rd_ready | output | NUM_RD | Per-requester request accepted this cycle |
| rsp_valid | output | NUM_RD | Per-requester response valid, one cycle wide |
| rsp_data | output | NUM_RD*DATA_W | Per-requester response data, requester i at bits [i*DATA_W +: DATA_W] |

## Verification
The hardest state to reach from the ports is a full waiter table that meets a same-cycle contest for slots. This needs more blocked requesters than there are slots, all parked on words that no one has produced yet. The stimulus first parks four requesters on four distinct absent words in a single cycle. A fifth requester, asking for an absent word, must then be refused, while a sixth, asking for a present word, is still served. In a separate step, three readers are parked, and two more requesters compete in one cycle for the one remaining slot, which checks the priority order. Wake-ups are also checked for exact timing: the scoreboard stores the expected cycle of each response, so a response that comes early, late or on the wrong lane is caught.

// File: rtl/fe_pkg.sv
package fe_pkg;

    // Source of a response lane update in a given cycle.
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_WAKE = 2'd2
    } rsp_src_e;

    // Width of a requester identifier; at least one bit.
    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fe_word_store.sv
// Data words with one presence flag each, plus write-first read views.
module fe_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int NUM_RD = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     clr_en,
    input  logic [ADDR_W-1:0]        clr_addr,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD-1:0]        rd_full,
    output logic [NUM_RD*DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0]             pres;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pres[clr_addr] = 1'b0;
        end
        // write is applied after clear so it wins on a shared address
        if (wr_en) begin
            st_d.pres[wr_addr] = 1'b1;
            st_d.mem[wr_addr]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_view
        logic [ADDR_W-1:0] a_q;
        logic              fwd;
        assign a_q = rd_addr[g*ADDR_W +: ADDR_W];
        assign fwd = wr_en && (wr_addr == a_q);
        assign rd_full[g]                  = st_q.pres[a_q] | fwd;
        assign rd_data[g*DATA_W +: DATA_W] = fwd ? wr_data : st_q.mem[a_q];
    end

endmodule

// File: rtl/fe_wait_table.sv
// Small associative table of parked reads, released by matching writes.
module fe_wait_table #(
    parameter int ADDR_W = 4,
    parameter int NUM_RD = 6,
    parameter int PEND_N = 4,
    parameter int IDW    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_RD-1:0]        ins_req,
    input  logic [NUM_RD*ADDR_W-1:0] ins_addr,
    output logic [NUM_RD-1:0]        ins_grant,
    output logic [NUM_RD-1:0]        busy,
    input  logic                     wake_en,
    input  logic [ADDR_W-1:0]        wake_addr,
    output logic [NUM_RD-1:0]        wake_hit
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [IDW-1:0]    id;
    } slot_t;

    typedef struct packed {
        slot_t [PEND_N-1:0] slot;
    } tbl_t;

    tbl_t tb_d, tb_q;

    always_comb begin : p_next
        logic [PEND_N-1:0] taken;
        logic              found;
        tb_d      = tb_q;
        ins_grant = '0;
        wake_hit  = '0;
        busy      = '0;
        taken     = '0;
        found     = 1'b0;
        // occupancy and release
        for (int j = 0; j < PEND_N; j++) begin
            taken[j] = tb_q.slot[j].vld;
            if (tb_q.slot[j].vld) begin
                busy[tb_q.slot[j].id] = 1'b1;
                if (wake_en && (tb_q.slot[j].addr == wake_addr)) begin
                    wake_hit[tb_q.slot[j].id] = 1'b1;
                    tb_d.slot[j].vld          = 1'b0;
                end
            end
        end
        // fixed-priority allocation: lowest requester first, lowest slot first
        for (int i = 0; i < NUM_RD; i++) begin
            found = 1'b0;
            if (ins_req[i]) begin
                for (int j = 0; j < PEND_N; j++) begin
                    if (!found && !taken[j]) begin
                        found             = 1'b1;
                        taken[j]          = 1'b1;
                        tb_d.slot[j].vld  = 1'b1;
                        tb_d.slot[j].addr = ins_addr[i*ADDR_W +: ADDR_W];
                        tb_d.slot[j].id   = IDW'(i);
                        ins_grant[i]      = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

endmodule

// File: rtl/fe_rsp_stage.sv
// Registered per-requester response lanes.
module fe_rsp_stage #(
    parameter int NUM_RD = 6,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_RD-1:0]        hit_fire,
    input  logic [NUM_RD*DATA_W-1:0] hit_data,
    input  logic [NUM_RD-1:0]        wake_hit,
    input  logic [DATA_W-1:0]        wake_data,
    output logic [NUM_RD-1:0]        rsp_valid,
    output logic [NUM_RD*DATA_W-1:0] rsp_data
);
    import fe_pkg::*;

    typedef struct packed {
        logic [NUM_RD-1:0]             vld;
        logic [NUM_RD-1:0][DATA_W-1:0] dat;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin : p_next
        rsp_src_e src;
        ln_d = ln_q;
        for (int i = 0; i < NUM_RD; i++) begin
            if (wake_hit[i]) begin
                src = RSP_WAKE;
            end else if (hit_fire[i]) begin
                src = RSP_HIT;
            end else begin
                src = RSP_IDLE;
            end
            case (src)
                RSP_WAKE: begin
                    ln_d.vld[i] = 1'b1;
                    ln_d.dat[i] = wake_data;
                end
                RSP_HIT: begin
                    ln_d.vld[i] = 1'b1;
                    ln_d.dat[i] = hit_data[i*DATA_W +: DATA_W];
                end
                default: begin
                    ln_d.vld[i] = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign rsp_valid = ln_q.vld;
    for (genvar g = 0; g < NUM_RD; g++) begin : g_out
        assign rsp_data[g*DATA_W +: DATA_W] = ln_q.dat[g];
    end

endmodule

// File: rtl/fe_tag_mem.sv
// Presence-tagged word memory: reads of absent words wait for the producer.
module fe_tag_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int NUM_RD = 6,
    parameter int PEND_N = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     clr_valid,
    input  logic [ADDR_W-1:0]        clr_addr,
    input  logic [NUM_RD-1:0]        rd_valid,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD-1:0]        rd_ready,
    output logic [NUM_RD-1:0]        rsp_valid,
    output logic [NUM_RD*DATA_W-1:0] rsp_data
);
    localparam int IDW = fe_pkg::id_width(NUM_RD);

    logic [NUM_RD-1:0]        word_full;
    logic [NUM_RD*DATA_W-1:0] word_data;
    logic [NUM_RD-1:0]        busy;
    logic [NUM_RD-1:0]        ins_req;
    logic [NUM_RD-1:0]        ins_grant;
    logic [NUM_RD-1:0]        wake_hit;
    logic [NUM_RD-1:0]        hit_fire;

    fe_word_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .NUM_RD(NUM_RD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clr_en  (clr_valid),
        .clr_addr(clr_addr),
        .rd_addr (rd_addr),
        .rd_full (word_full),
        .rd_data (word_data)
    );

    assign ins_req  = rd_valid & ~word_full & ~busy;
    assign rd_ready = ~busy & (word_full | ins_grant);
    assign hit_fire = rd_valid & rd_ready & word_full;

    fe_wait_table #(
        .ADDR_W(ADDR_W),
        .NUM_RD(NUM_RD),
        .PEND_N(PEND_N),
        .IDW   (IDW)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_req  (ins_req),
        .ins_addr (rd_addr),
        .ins_grant(ins_grant),
        .busy     (busy),
        .wake_en  (wr_valid),
        .wake_addr(wr_addr),
        .wake_hit (wake_hit)
    );

    fe_rsp_stage #(
        .NUM_RD(NUM_RD),
        .DATA_W(DATA_W)
    ) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_fire (hit_fire),
        .hit_data (word_data),
        .wake_hit (wake_hit),
        .wake_data(wr_data),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

endmodule

// File: rtl/fe_tag_mem_chk.sv
module fe_tag_mem_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int NUM_RD = 6,
    parameter int PEND_N = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_valid,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [NUM_RD-1:0]        rd_valid,
    input logic [NUM_RD*ADDR_W-1:0] rd_addr,
    input logic [NUM_RD-1:0]        rd_ready,
    input logic [NUM_RD-1:0]        rsp_valid,
    input logic [NUM_RD*DATA_W-1:0] rsp_data,
    input logic [NUM_RD-1:0]        busy,
    input logic [NUM_RD-1:0]        word_full,
    input logic [NUM_RD-1:0]        wake_hit
);
    for (genvar g = 0; g < NUM_RD; g++) begin : g_lane
        logic [ADDR_W-1:0] ra;
        logic [DATA_W-1:0] rd;
        assign ra = rd_addr[g*ADDR_W +: ADDR_W];
        assign rd = rsp_data[g*DATA_W +: DATA_W];

        AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            busy[g] |-> !rd_ready[g]); // R9

        AST_WAKE_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
            wake_hit[g] |=> (rsp_valid[g] && rd == $past(wr_data))); // R4

        AST_BYPASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[g] && !busy[g] && wr_valid && wr_addr == ra) |-> rd_ready[g]); // R6

        AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[g] && rd_ready[g] && wr_valid && wr_addr == ra)
            |=> (rsp_valid[g] && rd == $past(wr_data))); // R6

        AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[g] |-> $past((rd_valid[g] && rd_ready[g]) || wake_hit[g])); // R2

        AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(busy) == PEND_N && rd_valid[g] && !word_full[g]) |-> !rd_ready[g]); // R8
    end

endmodule

bind fe_tag_mem fe_tag_mem_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_RD(NUM_RD),
    .PEND_N(PEND_N)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .busy     (busy),
    .word_full(word_full),
    .wake_hit (wake_hit)
);

// File: tb/fe_tag_mem_tb.sv
module fe_tag_mem_tb;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NR = 6;
    localparam int PN = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              clr_valid = 1'b0;
    logic [AW-1:0]     clr_addr = '0;
    logic [NR-1:0]     rd_valid = '0;
    logic [NR*AW-1:0]  rd_addr = '0;
    logic [NR-1:0]     rd_ready;
    logic [NR-1:0]     rsp_valid;
    logic [NR*DW-1:0]  rsp_data;

    int ntests = 0;
    int nfail  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int            id;
        logic [DW-1:0] data;
        int            cyc;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model built from the requirements
    logic [DW-1:0] m_mem [1<<AW];
    bit            m_pres[1<<AW];
    bit            m_pv  [NR];
    int            m_pa  [NR];

    fe_tag_mem #(.ADDR_W(AW), .DATA_W(DW), .NUM_RD(NR), .PEND_N(PN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_valid(clr_valid), .clr_addr(clr_addr),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(int id, logic [DW-1:0] d, int c, string tag);
        exp_t e;
        e.id = id; e.data = d; e.cyc = c; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_rd(int i, int a);
        rd_valid[i] = 1'b1;
        rd_addr[i*AW +: AW] = AW'(a);
    endtask

    task automatic set_wr(int a, logic [DW-1:0] d);
        wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
    endtask

    task automatic chk_rdy(int i, bit e, string tag);
        ntests++;
        if (rd_ready[i] !== e) begin
            nfail++;
            $display("FAIL %s: rd_ready[%0d] actual=%b expected=%b", tag, i, rd_ready[i], e);
        end
    endtask

    // record what the accepted stimulus implies, then advance one cycle
    task automatic commit(string tag);
        logic [AW-1:0] a;
        bit byp;
        for (int i = 0; i < NR; i++) begin
            if (rd_valid[i] && rd_ready[i]) begin
                a = rd_addr[i*AW +: AW];
                byp = wr_valid && (wr_addr == a);
                if (m_pres[a] || byp) begin
                    push(i, byp ? wr_data : m_mem[a], cyc + 1, tag);
                end else begin
                    m_pv[i] = 1'b1;
                    m_pa[i] = int'(a);
                end
            end
        end
        if (wr_valid) begin
            for (int i = 0; i < NR; i++) begin
                if (m_pv[i] && m_pa[i] == int'(wr_addr)) begin
                    push(i, wr_data, cyc + 1, tag);
                    m_pv[i] = 1'b0;
                end
            end
            m_mem[wr_addr]  = wr_data;
            m_pres[wr_addr] = 1'b1;
        end
        if (clr_valid && !(wr_valid && wr_addr == clr_addr)) m_pres[clr_addr] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rd_valid = '0; wr_valid = 1'b0; clr_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NR; i++) begin
                if (rsp_valid[i]) begin
                    int k;
                    k = -1;
                    for (int j = 0; j < exp_q.size(); j++)
                        if (k < 0 && exp_q[j].id == i && exp_q[j].cyc == cyc) k = j;
                    ntests++;
                    if (k < 0) begin
                        nfail++;
                        $display("FAIL R4: lane %0d unexpected response actual=%h expected none", i, rsp_data[i*DW +: DW]);
                    end else begin
                        if (rsp_data[i*DW +: DW] !== exp_q[k].data) begin
                            nfail++;
                            $display("FAIL %s: lane %0d data actual=%h expected=%h", exp_q[k].tag, i, rsp_data[i*DW +: DW], exp_q[k].data);
                        end
                        exp_q.delete(k);
                    end
                end
            end
            for (int j = exp_q.size() - 1; j >= 0; j--) begin
                if (exp_q[j].cyc < cyc) begin
                    ntests++; nfail++;
                    $display("FAIL %s: lane %0d response missing actual=none expected=%h", exp_q[j].tag, exp_q[j].id, exp_q[j].data);
                    exp_q.delete(j);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin m_pres[i] = 1'b0; m_mem[i] = '0; end
        for (int i = 0; i < NR; i++) begin m_pv[i] = 1'b0; m_pa[i] = 0; end
        repeat (3) @(negedge clk);
        ntests++;
        if (rsp_valid !== '0) begin nfail++; $display("FAIL R1: rsp_valid in reset actual=%b expected=0", rsp_valid); end
        rst_n = 1'b1;
        @(negedge clk);
        ntests++;
        if (rsp_valid !== '0) begin nfail++; $display("FAIL R1: rsp_valid after reset actual=%b expected=0", rsp_valid); end

        // R1/R4: first read parks; no response during idle cycles
        set_rd(0, 3); #1; chk_rdy(0, 1'b1, "R1"); commit("R4");
        commit("R4"); commit("R4");
        // R9: waiting requester is not ready
        set_rd(0, 7); #1; chk_rdy(0, 1'b0, "R9"); commit("R9");
        set_wr(3, 16'hA5A5); commit("R4");
        // R9/R3: new read allowed in response cycle, hits stored data
        set_rd(0, 3); #1; chk_rdy(0, 1'b1, "R9"); commit("R3");
        set_rd(1, 3); #1; chk_rdy(1, 1'b1, "R3"); commit("R3");
        commit("R3");

        // R5/R11: three waiters on one word; other address does not release
        set_rd(0, 9); set_rd(1, 9); set_rd(2, 9); #1;
        chk_rdy(0, 1'b1, "R5"); chk_rdy(1, 1'b1, "R5"); chk_rdy(2, 1'b1, "R5");
        commit("R5");
        set_wr(10, 16'h0BAD); commit("R11");
        commit("R11");
        set_rd(0, 9); #1; chk_rdy(0, 1'b0, "R11"); commit("R11");
        set_wr(9, 16'h1234); commit("R5");
        commit("R5");

        // R6: same-cycle read and write on an absent word
        set_rd(2, 12); set_wr(12, 16'h7777); #1; chk_rdy(2, 1'b1, "R6"); commit("R6");
        commit("R6");

        // R7: clear empties a word; clear+write keeps the write
        clr_valid = 1'b1; clr_addr = 4'd3; commit("R7");
        set_rd(0, 3); #1; chk_rdy(0, 1'b1, "R7"); commit("R7");
        commit("R7");
        set_wr(3, 16'h3333); commit("R7");
        clr_valid = 1'b1; clr_addr = 4'd12; set_wr(12, 16'h8888); commit("R7");
        set_rd(1, 12); #1; chk_rdy(1, 1'b1, "R7"); commit("R7");
        commit("R7");

        // R8: fill the table, refuse an absent read, still serve a present one
        set_rd(0, 0); set_rd(1, 1); set_rd(2, 2); set_rd(3, 4); set_rd(4, 5); set_rd(5, 3); #1;
        chk_rdy(0, 1'b1, "R8"); chk_rdy(1, 1'b1, "R8"); chk_rdy(2, 1'b1, "R8"); chk_rdy(3, 1'b1, "R8");
        chk_rdy(4, 1'b0, "R8"); chk_rdy(5, 1'b1, "R8");
        commit("R8");
        set_wr(0, 16'h1000); commit("R8");
        set_rd(4, 5); #1; chk_rdy(4, 1'b1, "R8"); commit("R8");
        set_wr(1, 16'h1001); commit("R8");
        set_wr(2, 16'h1002); commit("R8");
        set_wr(4, 16'h1004); commit("R8");
        set_wr(5, 16'h1005); commit("R8");
        commit("R8");

        // R10: two requesters contend for the last slot
        set_rd(0, 6); set_rd(1, 7); set_rd(2, 8); commit("R10");
        set_rd(3, 11); set_rd(4, 11); #1;
        chk_rdy(3, 1'b1, "R10"); chk_rdy(4, 1'b0, "R10");
        commit("R10");
        set_wr(6, 16'h2006); commit("R10");
        set_wr(7, 16'h2007); commit("R10");
        set_wr(8, 16'h2008); commit("R10");
        set_wr(11, 16'h200B); commit("R10");
        set_rd(4, 11); #1; chk_rdy(4, 1'b1, "R10"); commit("R10");
        repeat (3) commit("R10");

        ntests++;
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL R4: outstanding expectations actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule